// File: doc/BRIEF.md
# Dual-Clock Elastic Receive Buffer

This block moves 5-bit line code groups from a receive clock recovered from the incoming bit stream into the station's local clock domain. The two clocks run at nominally equal but slightly different rates. Code groups go into a small ring of registers. A write pointer in the receive domain walks the ring, and a read pointer in the local domain walks it behind the writer. Both pointers are Gray-coded, so a pointer value seen from the other domain is never off by more than one step.

Upstream framing logic pulses `rx_gap` when it has seen a long enough run of idle code groups between packets. The write side then captures its current write address and raises a single request line toward the local domain. The request is the only control signal that crosses between the domains. The read side synchronizes the request and, on its rising edge, jumps the read pointer to the captured address corrected by a fixed amount. This re-centres the distance between the pointers while only idle code groups are in flight.

If clock drift carries the read pointer onto the write pointer, a comparator sampled on the local clock and on a copy of it delayed by a quarter period reports a collision. The block then raises a sticky error and outputs only idle code until the next re-centring.

Top module: `clkx_elastic_buf`

Write controller states are WR_RUN, WR_HOLD and WR_COOL:
- WR_RUN to WR_HOLD happens on `rx_gap`; the write address is captured and the request goes high.
- WR_HOLD to WR_COOL happens after HOLD_CYC receive cycles; the request goes low.
- WR_COOL to WR_RUN happens after COOL_CYC receive cycles. `rx_gap` is ignored outside WR_RUN.

Read controller states are RD_FLOW and RD_FAULT:
- RD_FLOW to RD_FAULT happens on a confirmed collision.
- RD_FAULT to RD_FLOW happens on a synchronized request edge.
- RD_FLOW to RD_FLOW happens on a synchronized request edge, which reloads the read pointer.

## Requirements
- R1: While `rst_n` is low, and after its release until data is written, `lc_code` is the idle code 5'b11111 and `lc_err` is 0.
- R2: Every non-idle code group written on `rx_code` appears on `lc_code` exactly once, in the order written. This holds while no collision occurs and while every `rx_gap` pulse lies within a run of idle code groups: at least 8 before the pulse and at least 8 after it.
- R3: With the two clock periods within 2 % of each other, and packets of at most 64 code groups each followed by an `rx_gap` re-centring, `lc_err` stays 0.
- R4: When the receive clock is faster and no re-centring occurs, the write pointer catches the read pointer and `lc_err` becomes 1.
- R5: When the local clock is faster and no re-centring occurs, the read pointer catches the write pointer and `lc_err` becomes 1.
- R6: In every local cycle in which `lc_err` is 1, `lc_code` is the idle code 5'b11111.
- R7: Once set, `lc_err` stays 1, even after the pointers have separated, until a re-centring triggered by `rx_gap` takes effect.
- R8: An `rx_gap` pulse clears `lc_err` within 10 local cycles. It leaves the read pointer at the captured write address plus SYNC_STAGES+1 minus READ_LAG, modulo the depth, and normal in-order flow (R2) resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rx_clk | input | 1 | Recovered receive clock |
| rx_code | input | 5 | Code group written each receive cycle |
| rx_gap | input | 1 | One-cycle pulse: minimum interpacket gap seen (receive domain) |
| lc_clk | input | 1 | Local clock |
| lc_clk_q | input | 1 | Local clock delayed by a quarter period |
| lc_code | output | 5 | Code group read each local cycle (local domain) |
| lc_err | output | 1 | Sticky overflow/underrun flag (local domain) |

## Verification
The bench builds the block with its defaults: 8 entries, a read lag of 4, two synchronizer stages, a hold of 8 and a cool-down of 4. At this depth a clock mismatch of about 2 % closes the four-entry margin in under two hundred cycles. Both overflow and underrun are therefore reached by a single long packet, in either clock ordering. Short packets at the same ratios show that each gap re-centring restores the margin before drift can use it up.

// File: rtl/clkx_eb_pkg.sv
package clkx_eb_pkg;

    typedef enum logic [1:0] {
        WR_RUN  = 2'd0,
        WR_HOLD = 2'd1,
        WR_COOL = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_FLOW  = 1'b0,
        RD_FAULT = 1'b1
    } rd_state_e;

    // conversions on a 16-bit carrier; callers zero-extend narrower values
    function automatic logic [15:0] to_gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [15:0] from_gray(input logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/clkx_eb_gray_ctr.sv
module clkx_eb_gray_ctr
    import clkx_eb_pkg::*;
#(
    parameter int W       = 3,
    parameter int RST_BIN = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         ld,
    input  logic [W-1:0] ld_bin,
    output logic [W-1:0] bin_q,
    output logic [W-1:0] gray_q
);

    logic [W-1:0] bin_nxt;

    always_comb begin
        bin_nxt = bin_q;
        if (ld) begin
            bin_nxt = ld_bin;
        end else if (adv) begin
            bin_nxt = bin_q + W'(1);
        end
    end

    // the Gray copy is registered so the other domain never sees a decode glitch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= W'(RST_BIN);
            gray_q <= W'(to_gray(16'(RST_BIN)));
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= W'(to_gray(16'(bin_nxt)));
        end
    end

    // R2: a plain advance moves exactly one bit of the Gray pointer
    a_r2_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld) |=> ($countones(gray_q ^ $past(gray_q)) == 1));

endmodule

// File: rtl/clkx_eb_store.sv
module clkx_eb_store #(
    parameter int                CODE_W    = 5,
    parameter int                PTR_W     = 3,
    parameter logic [CODE_W-1:0] IDLE_CODE = '1
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [CODE_W-1:0] rdata
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DEPTH*CODE_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [CODE_W-1:0] cell_q;

        always_ff @(posedge wclk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= IDLE_CODE;
            end else if (we && (waddr == PTR_W'(g))) begin
                cell_q <= wdata;
            end
        end

        assign flat[g*CODE_W +: CODE_W] = cell_q;
    end

    // read is a plain mux; the read side registers the result in its own domain
    assign rdata = flat[raddr*CODE_W +: CODE_W];

endmodule

// File: rtl/clkx_eb_wr_ctl.sv
module clkx_eb_wr_ctl
    import clkx_eb_pkg::*;
#(
    parameter int PTR_W    = 3,
    parameter int HOLD_CYC = 8,
    parameter int COOL_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gap_i,
    output logic [PTR_W-1:0] wptr_bin,
    output logic [PTR_W-1:0] wptr_gray,
    output logic [PTR_W-1:0] held_gray,
    output logic             req_o
);

    localparam int CNT_MAX = (HOLD_CYC > COOL_CYC) ? HOLD_CYC : COOL_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;

    wr_state_e        st, nxt;
    logic [CNT_W-1:0] cnt;

    // the pointer advances every receive cycle: one code group per clock
    clkx_eb_gray_ctr #(.W(PTR_W), .RST_BIN(0)) u_wptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (1'b1),
        .ld     (1'b0),
        .ld_bin ('0),
        .bin_q  (wptr_bin),
        .gray_q (wptr_gray)
    );

    always_comb begin
        nxt = st;
        unique case (st)
            WR_RUN:  nxt = gap_i ? WR_HOLD : WR_RUN;
            WR_HOLD: nxt = (cnt == '0) ? WR_COOL : WR_HOLD;
            WR_COOL: nxt = (cnt == '0) ? WR_RUN : WR_COOL;
            default: nxt = WR_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= WR_RUN;
        end else begin
            st <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_o     <= 1'b0;
            held_gray <= '0;
            cnt       <= '0;
        end else begin
            req_o <= (nxt == WR_HOLD);
            if (st == WR_RUN && nxt == WR_HOLD) begin
                held_gray <= wptr_gray;
            end
            if (st != nxt) begin
                cnt <= (nxt == WR_HOLD) ? CNT_W'(HOLD_CYC - 1) : CNT_W'(COOL_CYC - 1);
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // R8: the crossing request only rises in answer to a gap pulse
    a_r8_req_from_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(gap_i));

    // R8: the captured address is frozen for as long as the request is up
    a_r8_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o)) |-> $stable(held_gray));

endmodule

// File: rtl/clkx_eb_rd_ctl.sv
module clkx_eb_rd_ctl
    import clkx_eb_pkg::*;
#(
    parameter int                CODE_W      = 5,
    parameter int                PTR_W       = 3,
    parameter int                READ_LAG    = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [CODE_W-1:0] IDLE_CODE   = '1
) (
    input  logic              clk,
    input  logic              clk_q,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [PTR_W-1:0]  held_gray,
    input  logic [PTR_W-1:0]  wptr_gray,
    input  logic [CODE_W-1:0] rdata,
    output logic [PTR_W-1:0]  rptr_bin,
    output logic [CODE_W-1:0] code_o,
    output logic              err_o
);

    localparam int DEPTH   = 1 << PTR_W;
    localparam int RST_POS = (DEPTH - READ_LAG) % DEPTH;
    // the writer keeps moving while the request crosses; fold that latency in
    localparam int LD_ADJ  = (SYNC_STAGES + 1 + DEPTH - READ_LAG) % DEPTH;

    rd_state_e        st, nxt;
    logic [SYNC_STAGES-1:0] sync_r;
    logic             sync_prev;
    logic             rst_evt;
    logic [PTR_W-1:0] rptr_gray;
    logic [PTR_W-1:0] held_bin;
    logic [PTR_W-1:0] ld_bin;
    logic             ptr_eq;
    logic             eq_edge;
    logic             eq_quarter;
    logic             ld_q;
    logic             hit;

    // single crossing line: a short flop chain, each stage a settling interval
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_r[s] <= 1'b0;
            end else if (s == 0) begin
                sync_r[s] <= req_i;
            end else begin
                sync_r[s] <= sync_r[(s == 0) ? 0 : s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev <= 1'b0;
        end else begin
            sync_prev <= sync_r[SYNC_STAGES-1];
        end
    end

    assign rst_evt  = sync_r[SYNC_STAGES-1] && !sync_prev;
    assign held_bin = PTR_W'(from_gray(16'(held_gray)));
    assign ld_bin   = held_bin + PTR_W'(LD_ADJ);

    clkx_eb_gray_ctr #(.W(PTR_W), .RST_BIN(RST_POS)) u_rptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (1'b1),
        .ld     (rst_evt),
        .ld_bin (ld_bin),
        .bin_q  (rptr_bin),
        .gray_q (rptr_gray)
    );

    // collision: the comparator must read equal on the edge and a quarter later
    assign ptr_eq = (wptr_gray == rptr_gray);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_edge <= 1'b0;
            ld_q    <= 1'b0;
        end else begin
            eq_edge <= ptr_eq;
            ld_q    <= rst_evt;
        end
    end

    always_ff @(posedge clk_q or negedge rst_n) begin
        if (!rst_n) begin
            eq_quarter <= 1'b0;
        end else begin
            eq_quarter <= ptr_eq;
        end
    end

    // the edge sample taken at a reload still saw the old read pointer
    assign hit = eq_edge && eq_quarter && !ld_q;

    always_comb begin
        nxt = st;
        unique case (st)
            RD_FLOW:  nxt = rst_evt ? RD_FLOW : (hit ? RD_FAULT : RD_FLOW);
            RD_FAULT: nxt = rst_evt ? RD_FLOW : RD_FAULT;
            default:  nxt = RD_FLOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RD_FLOW;
        end else begin
            st <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= IDLE_CODE;
            err_o  <= 1'b0;
        end else begin
            code_o <= (nxt == RD_FAULT) ? IDLE_CODE : rdata;
            err_o  <= (nxt == RD_FAULT);
        end
    end

    // R6: a raised flag never lets stored data through
    a_r6_idle_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (code_o == IDLE_CODE));

    // R7: only a synchronized gap request lowers the flag
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !rst_evt) |=> err_o);

    // R8: a request edge clears the flag in the next cycle
    a_r8_evt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> !err_o);

    // R8: the read pointer lands on the corrected captured address
    a_r8_evt_loads: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (rptr_bin == $past(ld_bin)));

endmodule

// File: rtl/clkx_elastic_buf.sv
module clkx_elastic_buf #(
    parameter int                CODE_W      = 5,
    parameter int                PTR_W       = 3,
    parameter int                READ_LAG    = 4,
    parameter int                SYNC_STAGES = 2,
    parameter int                HOLD_CYC    = 8,
    parameter int                COOL_CYC    = 4,
    parameter logic [CODE_W-1:0] IDLE_CODE   = '1
) (
    input  logic              rst_n,
    input  logic              rx_clk,
    input  logic [CODE_W-1:0] rx_code,
    input  logic              rx_gap,
    input  logic              lc_clk,
    input  logic              lc_clk_q,
    output logic [CODE_W-1:0] lc_code,
    output logic              lc_err
);

    logic [PTR_W-1:0]  wptr_bin;
    logic [PTR_W-1:0]  wptr_gray;
    logic [PTR_W-1:0]  held_gray;
    logic              req;
    logic [PTR_W-1:0]  rptr_bin;
    logic [CODE_W-1:0] rdata;

    clkx_eb_wr_ctl #(
        .PTR_W    (PTR_W),
        .HOLD_CYC (HOLD_CYC),
        .COOL_CYC (COOL_CYC)
    ) u_wr (
        .clk       (rx_clk),
        .rst_n     (rst_n),
        .gap_i     (rx_gap),
        .wptr_bin  (wptr_bin),
        .wptr_gray (wptr_gray),
        .held_gray (held_gray),
        .req_o     (req)
    );

    clkx_eb_store #(
        .CODE_W    (CODE_W),
        .PTR_W     (PTR_W),
        .IDLE_CODE (IDLE_CODE)
    ) u_store (
        .wclk  (rx_clk),
        .rst_n (rst_n),
        .we    (1'b1),
        .waddr (wptr_bin),
        .wdata (rx_code),
        .raddr (rptr_bin),
        .rdata (rdata)
    );

    clkx_eb_rd_ctl #(
        .CODE_W      (CODE_W),
        .PTR_W       (PTR_W),
        .READ_LAG    (READ_LAG),
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_CODE   (IDLE_CODE)
    ) u_rd (
        .clk       (lc_clk),
        .clk_q     (lc_clk_q),
        .rst_n     (rst_n),
        .req_i     (req),
        .held_gray (held_gray),
        .wptr_gray (wptr_gray),
        .rdata     (rdata),
        .rptr_bin  (rptr_bin),
        .code_o    (lc_code),
        .err_o     (lc_err)
    );

endmodule

// File: tb/clkx_elastic_buf_tb_top.sv
`timescale 1ns/1ps
module clkx_elastic_buf_tb_top;

    localparam logic [4:0] IDLE = 5'b11111;
    localparam real LC_HALF = 10.2;

    logic       rst_n = 1'b0;
    logic       rx_clk = 1'b0;
    logic       lc_clk = 1'b0;
    logic       lc_clk_q = 1'b0;
    logic [4:0] rx_code = IDLE;
    logic       rx_gap = 1'b0;
    logic [4:0] lc_code;
    logic       lc_err;

    real rx_half = 10.0;  // 50 MHz receive clock, adjustable for drift direction
    int  n_tests = 0;
    int  n_fail = 0;
    int  err_cycles = 0;
    int  idle_viol = 0;
    bit  sb_on = 1'b0;
    bit  finished = 1'b0;
    logic [4:0] exp_q[$];

    clkx_elastic_buf dut_i (
        .rst_n    (rst_n),
        .rx_clk   (rx_clk),
        .rx_code  (rx_code),
        .rx_gap   (rx_gap),
        .lc_clk   (lc_clk),
        .lc_clk_q (lc_clk_q),
        .lc_code  (lc_code),
        .lc_err   (lc_err)
    );

    initial forever #(rx_half) rx_clk = ~rx_clk;
    initial begin
        #3.0;
        forever #(LC_HALF) lc_clk = ~lc_clk;
    end
    initial begin
        #(3.0 + LC_HALF / 2.0);
        forever #(LC_HALF) lc_clk_q = ~lc_clk_q;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard for each non-idle group seen on the output
    always @(negedge lc_clk) begin
        if (rst_n) begin
            if (lc_err) begin
                err_cycles++;
                if (lc_code != IDLE) idle_viol++;
            end
            if (sb_on && lc_code != IDLE) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected group", int'(lc_code), -1);
                end else begin
                    logic [4:0] e;
                    e = exp_q.pop_front();
                    check(lc_code == e, "R2 order", int'(lc_code), int'(e));
                end
            end
        end
    end

    task automatic send_pkt(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge rx_clk);
            rx_code = 5'((base + i * 7) % 31);
            rx_gap  = 1'b0;
            if (sb_on) exp_q.push_back(rx_code);
        end
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rx_clk);
            rx_code = IDLE;
            rx_gap  = 1'b0;
        end
    endtask

    task automatic send_gap();
        send_idle(8);
        @(negedge rx_clk);
        rx_code = IDLE;
        rx_gap  = 1'b1;
        send_idle(10);
    endtask

    task automatic wait_lc(input int n);
        for (int i = 0; i < n; i++) @(negedge lc_clk);
    endtask

    initial begin
        int e0;
        // R1: reset state
        repeat (5) @(negedge rx_clk);
        @(negedge lc_clk);
        check(lc_code == IDLE, "R1 code in reset", int'(lc_code), int'(IDLE));
        check(lc_err == 1'b0, "R1 err in reset", int'(lc_err), 0);
        @(negedge rx_clk);
        #1 rst_n = 1'b1;
        send_idle(20);
        @(negedge lc_clk);
        check(lc_code == IDLE, "R1 code after release", int'(lc_code), int'(IDLE));
        check(lc_err == 1'b0, "R1 err after release", int'(lc_err), 0);

        // R2/R3: receive clock 2 % fast, short packets with re-centring
        sb_on = 1'b1;
        send_gap();
        e0 = err_cycles;
        for (int p = 0; p < 6; p++) begin
            send_pkt(64, p * 3);
            send_gap();
        end
        wait_lc(20);
        check(err_cycles == e0, "R3 no error, rx fast", err_cycles - e0, 0);
        check(exp_q.size() == 0, "R2 all delivered, rx fast", exp_q.size(), 0);

        // R4: long packet with no gap overruns the reader
        sb_on = 1'b0;
        send_pkt(400, 5);
        @(negedge lc_clk);
        check(lc_err == 1'b1, "R4 overflow flagged", int'(lc_err), 1);
        check(lc_code == IDLE, "R6 idle while flagged", int'(lc_code), int'(IDLE));

        // R7: flag holds with no gap request
        send_idle(60);
        @(negedge lc_clk);
        check(lc_err == 1'b1, "R7 sticky after overflow", int'(lc_err), 1);

        // R8: re-centring clears and restores flow
        send_gap();
        wait_lc(2);
        check(lc_err == 1'b0, "R8 cleared after gap", int'(lc_err), 0);
        exp_q.delete();
        sb_on = 1'b1;
        e0 = err_cycles;
        for (int p = 0; p < 3; p++) begin
            send_pkt(64, 11 + p);
            send_gap();
        end
        wait_lc(20);
        check(err_cycles == e0, "R8 clean flow after recovery", err_cycles - e0, 0);
        check(exp_q.size() == 0, "R8 R2 delivered after recovery", exp_q.size(), 0);

        // R3 with the local clock 2 % fast
        rx_half = 10.4;
        send_gap();
        e0 = err_cycles;
        for (int p = 0; p < 4; p++) begin
            send_pkt(64, 20 + p);
            send_gap();
        end
        wait_lc(20);
        check(err_cycles == e0, "R3 no error, local fast", err_cycles - e0, 0);
        check(exp_q.size() == 0, "R2 all delivered, local fast", exp_q.size(), 0);

        // R5: reader overtakes a slower writer
        sb_on = 1'b0;
        send_pkt(400, 9);
        @(negedge lc_clk);
        check(lc_err == 1'b1, "R5 underrun flagged", int'(lc_err), 1);
        send_idle(30);
        @(negedge lc_clk);
        check(lc_err == 1'b1, "R7 sticky after underrun", int'(lc_err), 1);
        send_gap();
        wait_lc(2);
        check(lc_err == 1'b0, "R8 cleared after underrun", int'(lc_err), 0);

        check(idle_viol == 0, "R6 idle on every flagged cycle", idle_viol, 0);
        check(err_cycles > 0, "R6 flagged cycles observed", err_cycles, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule